// File: doc/BRIEF.md
# Conversion Pacing and Data-Ready Generator

This block sets the pace of a delta-sigma converter's digital side from a single master clock. A first divider produces a one-cycle modulator clock enable once every `MOD_BASE * 2^speed` master cycles. A second counter marks the end of each conversion period, which lasts `CONV_BASE * 2^rate` modulator ticks. At every period boundary the 24-bit result on `result_i` is captured into the output data register, and the active-low ready flag drops to tell the host that a fresh word can be read.

The ready flag is raised again either when the host reports a finished read, or on its own a fixed `LEAD` master cycles before the next capture, so that a read never overlaps an update. Timing can be realigned in two ways. Holding the sync pin low clears all timing and keeps it cleared. A sync command strobe clears timing and then holds the modulator until the serial clock edge that follows; counting resumes only after that edge. Changing the speed or rate setting also restarts the period from zero.

Top module: `conv_pace_gen`

## Requirements
- R1: While reset is asserted, `ready_n_o` is 1, `data_o` is 0, `mod_en_o` is 0 and `serial_en_o` is 1.
- R2: `mod_en_o` is a single-cycle pulse. Counting from the edge that leaves the timing cleared, it first appears after `M-1` edges and then every `M` edges, where `M = MOD_BASE * 2^speed_i`.
- R3: The period is `P = M * CONV_BASE * 2^rate`. Counting from the edge that leaves the timing cleared, the first capture happens on edge number `P`, and each later capture follows `P` edges after the one before.
- R4: A `rate_i` code of 3 behaves exactly like code 2. Switching between codes 2 and 3 does not restart the period.
- R5: On a capture edge, `data_o` takes the value of `result_i` and `ready_n_o` goes to 0. `ready_n_o` falls on no other edge.
- R6: Without a read, `ready_n_o` returns to 1 on the edge `LEAD` edges before the next capture, and `data_o` keeps its old word until that capture.
- R7: A one-cycle `rd_done_i` pulse sets `ready_n_o` to 1 on that edge. It changes neither `data_o` nor the capture timing.
- R8: On every edge where `sync_n_i` is 0, the timing is cleared, `ready_n_o` is forced to 1, `mod_en_o` stays 0 and `serial_en_o` goes to 0. The first edge with `sync_n_i` at 1 counts as the first edge of a new period.
- R9: A `sync_cmd_i` pulse clears the timing and sets `ready_n_o` to 1. No `mod_en_o` pulse and no capture occurs until an edge on which `sclk_edge_i` is 1. That edge still leaves the timing cleared, and the period (R3) counts from it.
- R10: A change of `speed_i`, or of the effective rate, clears the timing on the edge where it is first seen. The next capture comes `P` edges later, with `P` taken from the new setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| speed_i | input | 1 | Modulator divider select: 0 gives MOD_BASE, 1 gives 2*MOD_BASE |
| rate_i | input | 2 | Period multiplier exponent, 0 to 2 (3 is treated as 2) |
| sync_n_i | input | 1 | Sync pin, active low; holds the timing cleared while low |
| sync_cmd_i | input | 1 | One-cycle strobe on the last serial clock of a sync command |
| sclk_edge_i | input | 1 | One-cycle indication that a serial clock edge was seen |
| rd_done_i | input | 1 | One-cycle strobe: host finished reading the data register |
| result_i | input | DATA_W | Conversion result to be captured at the period boundary |
| mod_en_o | output | 1 | Modulator clock enable pulse |
| ready_n_o | output | 1 | Data-ready flag, active low |
| data_o | output | DATA_W | Output data register |
| serial_en_o | output | 1 | Serial interface enable; low after an edge that saw the sync pin low |

## Verification
The bench builds the block with MOD_BASE = 4, CONV_BASE = 5 and LEAD = 4, so every period lies between 20 and 160 master cycles. That short range lets the bench sweep all eight speed and rate-code pairs and, for each pair, measure the exact capture edge, the early ready release and the modulator tick count against the formula. It also exercises read release, sync-pin and sync-command realignment (including a hold longer than a full period), a mid-period restart caused by a setting change, and a 2-to-3 rate-code swap that must leave the period undisturbed.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef struct packed {
        logic       speed;
        logic [1:0] rate;
    } cpg_cfg_t;

    // Rate code 3 is folded onto code 2.
    function automatic logic [1:0] eff_rate(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/cpg_mod_div.sv
module cpg_mod_div #(
    parameter int MOD_BASE = 128,
    localparam int CW = $clog2(2 * MOD_BASE) + 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    input  logic speed_i,
    output logic tick_o
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_st_t;

    div_st_t       st_d, st_q;
    logic [CW-1:0] last;

    always_comb begin
        last = speed_i ? CW'(2 * MOD_BASE - 1) : CW'(MOD_BASE - 1);
        st_d = st_q;
        if (clr_i || (st_q.cnt >= last)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = !clr_i && (st_q.cnt == last);

    // R2: the enable is a one-cycle pulse
    a_r2_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);

endmodule

// File: rtl/cpg_period_timer.sv
module cpg_period_timer #(
    parameter int MOD_BASE  = 128,
    parameter int CONV_BASE = 1280,
    parameter int LEAD      = 8,
    localparam int PW = $clog2(8 * MOD_BASE * CONV_BASE) + 1
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clr_i,
    input  logic       speed_i,
    input  logic [1:0] rate_i,
    output logic       boundary_o,
    output logic       early_o
);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } per_st_t;

    per_st_t       st_d, st_q;
    logic [PW-1:0] last;
    logic [PW-1:0] early_pt;
    logic [2:0]    shamt;

    always_comb begin
        shamt    = 3'(speed_i) + 3'(rate_i);
        last     = (PW'(MOD_BASE * CONV_BASE) << shamt) - 1'b1;
        early_pt = last - PW'(LEAD);
        st_d     = st_q;
        if (clr_i || (st_q.cnt >= last)) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign boundary_o = !clr_i && (st_q.cnt == last);
    assign early_o    = !clr_i && (st_q.cnt == early_pt);

    // R3: while timing runs under one setting, the count never passes the period end
    a_r3_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |-> (st_q.cnt <= last));

    // R6: the early release precedes the boundary, never coincides with it
    a_r6_early_not_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
        early_o |-> !boundary_o);

endmodule

// File: rtl/cpg_ready_reg.sv
module cpg_ready_reg #(
    parameter int DATA_W = 24
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              force_hi_i,
    input  logic              boundary_i,
    input  logic              early_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              ready_n_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              ready_n;
        logic [DATA_W-1:0] data;
    } rdy_st_t;

    rdy_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_hi_i) begin
            st_d.ready_n = 1'b1;
        end else if (boundary_i) begin
            st_d.ready_n = 1'b0;
            st_d.data    = result_i;
        end else if (early_i || rd_done_i) begin
            st_d.ready_n = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ready_n <= 1'b1;
            st_q.data    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_n_o = st_q.ready_n;
    assign data_o    = st_q.data;

    // R5: a falling flag always comes with the word present at the capture edge
    a_r5_load_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ready_n_o) |-> (data_o == $past(result_i)));

    // R7: a finished read releases the flag and leaves the data alone
    a_r7_read_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_done_i && !boundary_i) |=> (ready_n_o && $stable(data_o)));

    // R6: the early point releases the flag
    a_r6_lead_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        early_i |=> ready_n_o);

endmodule

// File: rtl/conv_pace_gen.sv
module conv_pace_gen #(
    parameter int DATA_W    = 24,
    parameter int MOD_BASE  = 128,
    parameter int CONV_BASE = 1280,
    parameter int LEAD      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              speed_i,
    input  logic [1:0]        rate_i,
    input  logic              sync_n_i,
    input  logic              sync_cmd_i,
    input  logic              sclk_edge_i,
    input  logic              rd_done_i,
    input  logic [DATA_W-1:0] result_i,
    output logic              mod_en_o,
    output logic              ready_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              serial_en_o
);

    import cpg_pkg::*;

    typedef struct packed {
        cpg_cfg_t cfg;
        logic     cmd_hold;
        logic     ser_en;
    } ctl_st_t;

    ctl_st_t  st_d, st_q;
    cpg_cfg_t cfg_in;
    logic     cfg_chg;
    logic     clr;
    logic     force_hi;
    logic     boundary;
    logic     early;

    always_comb begin
        cfg_in.speed = speed_i;
        cfg_in.rate  = eff_rate(rate_i);
        cfg_chg      = (cfg_in != st_q.cfg);
        force_hi     = !sync_n_i || sync_cmd_i;
        clr          = force_hi || st_q.cmd_hold || cfg_chg;

        st_d        = st_q;
        st_d.cfg    = cfg_in;
        st_d.ser_en = sync_n_i;
        if (!sync_n_i) begin
            st_d.cmd_hold = 1'b0;
        end else if (sync_cmd_i) begin
            st_d.cmd_hold = 1'b1;
        end else if (sclk_edge_i) begin
            st_d.cmd_hold = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cfg      <= '0;
            st_q.cmd_hold <= 1'b0;
            st_q.ser_en   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign serial_en_o = st_q.ser_en;

    cpg_mod_div #(
        .MOD_BASE (MOD_BASE)
    ) u_mod_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr),
        .speed_i (cfg_in.speed),
        .tick_o  (mod_en_o)
    );

    cpg_period_timer #(
        .MOD_BASE  (MOD_BASE),
        .CONV_BASE (CONV_BASE),
        .LEAD      (LEAD)
    ) u_period (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .clr_i      (clr),
        .speed_i    (cfg_in.speed),
        .rate_i     (cfg_in.rate),
        .boundary_o (boundary),
        .early_o    (early)
    );

    cpg_ready_reg #(
        .DATA_W (DATA_W)
    ) u_ready (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .force_hi_i (force_hi),
        .boundary_i (boundary),
        .early_i    (early),
        .rd_done_i  (rd_done_i),
        .result_i   (result_i),
        .ready_n_o  (ready_n_o),
        .data_o     (data_o)
    );

    // R3: the period end from one counter lands on a modulator tick from the other
    a_r3_boundary_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary |-> mod_en_o);

    // R8: a low sync pin quiets the timing and the serial side
    a_r8_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_n_i |=> (ready_n_o && !mod_en_o && !serial_en_o));

    // R9: a sync command releases the flag and stops the modulator
    a_r9_cmd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_cmd_i |=> (ready_n_o && !mod_en_o));

    // R10: a setting change leaves no tick on the following cycle
    a_r10_cfg_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_chg |=> !mod_en_o);

endmodule

// File: tb/conv_pace_gen_tb.sv
module conv_pace_gen_tb;

    localparam int DW    = 24;
    localparam int MB    = 4;
    localparam int CB    = 5;
    localparam int LD    = 4;
    localparam int LIMIT = 2000;

    logic          clk = 1'b0;
    logic          rst_ni;
    logic          speed;
    logic [1:0]    rate;
    logic          sync_n;
    logic          sync_cmd;
    logic          sclk_edge;
    logic          rd_done;
    logic [DW-1:0] result;
    logic          mod_en;
    logic          ready_n;
    logic [DW-1:0] data;
    logic          serial_en;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    conv_pace_gen #(
        .DATA_W    (DW),
        .MOD_BASE  (MB),
        .CONV_BASE (CB),
        .LEAD      (LD)
    ) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .speed_i     (speed),
        .rate_i      (rate),
        .sync_n_i    (sync_n),
        .sync_cmd_i  (sync_cmd),
        .sclk_edge_i (sclk_edge),
        .rd_done_i   (rd_done),
        .result_i    (result),
        .mod_en_o    (mod_en),
        .ready_n_o   (ready_n),
        .data_o      (data),
        .serial_en_o (serial_en)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int mod_div(input int s);
        return MB << s;
    endfunction

    function automatic int period(input int s, input int r);
        int rr;
        rr = (r == 3) ? 2 : r;
        return (MB << s) * (CB << rr);
    endfunction

    // tick until ready_n equals lvl; n accumulates edges
    task automatic run_until(input logic lvl, inout int n);
        do begin
            tick();
            n++;
        end while (ready_n !== lvl && n < LIMIT);
    endtask

    initial begin
        int n;
        int first;
        int pulses;
        int bad;
        int p;
        logic [DW-1:0] v1;
        logic [DW-1:0] v2;

        rst_ni    = 1'b0;
        speed     = 1'b0;
        rate      = 2'd0;
        sync_n    = 1'b1;
        sync_cmd  = 1'b0;
        sclk_edge = 1'b0;
        rd_done   = 1'b0;
        result    = '0;
        tick();
        tick();
        // R1: reset state
        check("R1 ready_n", int'(ready_n), 1);
        check("R1 data", int'(data), 0);
        check("R1 mod_en", int'(mod_en), 0);
        check("R1 serial_en", int'(serial_en), 1);
        rst_ni = 1'b1;
        tick();

        // Sweep every speed and rate code, realigned by the sync pin each time
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 4; r++) begin
                p  = period(s, r);
                v1 = DW'(32'h00C3A5 * (s * 4 + r + 1));
                v2 = DW'(32'h5A1F07 + 32'h1111 * (s * 4 + r));
                speed  = s[0];
                rate   = r[1:0];
                sync_n = 1'b0;
                tick();
                tick();
                check("R8 ready_n while pin low", int'(ready_n), 1);
                check("R8 serial_en while pin low", int'(serial_en), 0);
                check("R8 mod_en while pin low", int'(mod_en), 0);
                result = v1;
                sync_n = 1'b1;
                n = 0; first = 0; pulses = 0;
                do begin
                    tick();
                    n++;
                    if (mod_en) begin
                        pulses++;
                        if (first == 0) first = n;
                    end
                end while (ready_n && n < LIMIT);
                check((r == 3) ? "R4 period for code 3" : "R3 first capture edge", n, p);
                check("R2 first tick", first, mod_div(s) - 1);
                check("R2 ticks per period", pulses, p / mod_div(s));
                check("R5 captured word", int'(data), int'(v1));
                check("R8 serial_en after release", int'(serial_en), 1);

                result = v2;
                n = 0;
                run_until(1'b1, n);
                check("R6 early release edge", n, p - LD);
                check("R6 old word kept", int'(data), int'(v1));
                run_until(1'b0, n);
                check("R3 next capture edge", n, p);
                check("R5 second word", int'(data), int'(v2));
            end
        end

        // R7: read release (setting is speed 1, rate code 3)
        p = period(1, 3);
        tick();
        rd_done = 1'b1;
        result  = 24'hABCDEF;
        tick();
        rd_done = 1'b0;
        check("R7 ready_n after read", int'(ready_n), 1);
        check("R7 data after read", int'(data), int'(v2));
        n = 2;
        run_until(1'b0, n);
        check("R7 capture timing unchanged", n, p);
        check("R7 new word", int'(data), 24'hABCDEF);

        // R9: sync command holds until a serial clock edge
        tick();
        tick();
        sync_cmd = 1'b1;
        tick();
        sync_cmd = 1'b0;
        check("R9 ready_n after command", int'(ready_n), 1);
        bad = 0;
        for (int k = 0; k < p + 6; k++) begin
            tick();
            if (!ready_n || mod_en) bad++;
        end
        check("R9 held without serial edge", bad, 0);
        result    = 24'h13579B;
        sclk_edge = 1'b1;
        tick();
        sclk_edge = 1'b0;
        n = 0; first = 0;
        do begin
            tick();
            n++;
            if (mod_en && first == 0) first = n;
        end while (ready_n && n < LIMIT);
        check("R9 capture after serial edge", n, p);
        check("R9 first tick after serial edge", first, mod_div(1) - 1);
        check("R9 word", int'(data), 24'h13579B);

        // R10: mid-period setting change restarts from the new setting
        tick();
        tick();
        speed = 1'b0;
        rate  = 2'd0;
        tick();
        p = period(0, 0);
        n = 0;
        run_until(1'b1, n);
        check("R10 early release after change", n, p - LD);
        run_until(1'b0, n);
        check("R10 capture after change", n, p);

        // R4: swapping rate code 2 to 3 mid-period does not restart
        rate = 2'd2;
        tick();
        p = period(0, 2);
        n = 0;
        run_until(1'b1, n);
        run_until(1'b0, n);
        check("R10 capture after change to code 2", n, p);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            tick();
            n++;
        end
        rate = 2'd3;
        run_until(1'b1, n);
        run_until(1'b0, n);
        check("R4 no restart on 2 to 3 swap", n, p);

        // R8: pin low forces ready high even while a word is pending
        sync_n = 1'b0;
        tick();
        check("R8 ready_n forced by pin", int'(ready_n), 1);
        sync_n = 1'b1;
        tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule